// File: doc/BRIEF.md
# Lamp Strike Frequency Sweep Generator

This block sequences the ignition attempt of a lamp inverter and generates the digital code for the DAC that sets the oscillator frequency during the attempt. A level enable starts a 16-sweep timebase. Sweep 0 is a quiet power-on delay. Sweeps 1 to 15 are strike sweeps. In each strike sweep the code climbs linearly from 0 to full scale and then falls back to 0. Code 0 maps to the normal run frequency and full scale maps to five times that frequency, so the drive sweeps through every resonance the transformer and lamp could present.

An over-voltage flag freezes the code at its present value, so the highest safe voltage stays on the lamp for the rest of the attempt. The sweep count keeps advancing while the code is frozen, so the timeout is not delayed. A lamp-ignited flag ends the attempt at once and hands frequency control back to the fixed run reference. If the lamp has not ignited by the end of the fifteenth strike sweep, a timeout pulse is issued. A new attempt can only start after the enable has been dropped and raised again.

All pins are plain level signals sampled on the rising ramp clock. No data stream passes through the block, so it has no valid/ready handshake and nothing can back-pressure it.

Top module: `strike_sweep_gen`

## Requirements
- R1: While reset is asserted, and while `seq_en` is low, `use_dac`, `dac_code`, `sweep_idx` and `timeout` are all 0. After `seq_en` goes low, this idle state is reached one clock later.
- R2: The first clock edge that samples `seq_en` high starts the timebase. For the 1024 cycles that follow (sweep 0, the power-on delay), `use_dac` is 0 and `dac_code` is 0.
- R3: During an attempt, `sweep_idx` equals the number of cycles since the starting edge divided by 1024, counted from 0 up to 15.
- R4: In sweeps 1 to 15, `use_dac` is 1 and `dac_code` equals the position within the sweep divided by 4. This gives 0 in the first cycle of each sweep and 255 in its last cycle.
- R5: When `ovp` is sampled high during a strike sweep, `dac_code` keeps, from the next cycle until the attempt ends, the value it showed in that cycle. `sweep_idx` keeps advancing while the code is held.
- R6: `ovp` has no effect during the delay sweep. Strike sweeps that follow ramp normally.
- R7: When `ignited` is sampled high during a strike sweep, `use_dac` and `dac_code` are 0 from the next cycle on, and `sweep_idx` holds its value until `seq_en` drops.
- R8: `ignited` has no effect during the delay sweep. Strike starts on schedule at sweep 1.
- R9: If the last cycle of sweep 15 passes without ignition, `timeout` is high for exactly the next cycle. From that cycle on, `use_dac` is 0 and `sweep_idx` stays at 15 until `seq_en` drops.
- R10: Dropping `seq_en` in any phase and raising it again restarts the sequence at sweep 0 with the code unfrozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ramp clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_en | input | 1 | Level enable for the delay and strike sequence |
| ovp | input | 1 | Output over-voltage detected |
| ignited | input | 1 | Lamp ignition detected |
| dac_code | output | 8 | Frequency DAC code; 0 is run frequency, 255 is five times run |
| use_dac | output | 1 | 1 selects the DAC code, 0 selects the fixed run reference |
| sweep_idx | output | 4 | Current sweep of the timebase |
| timeout | output | 1 | One-cycle pulse when the strike attempt expires |

## Verification
Every cycle, the assertions check the following. `timeout` is a single-cycle pulse that only comes with the DAC deselected at sweep 15. Ignition removes the DAC selection on the next cycle. A held code does not move while the DAC stays selected. The DAC is never selected during sweep 0, and it is released within one cycle of the enable dropping. Only the bench's scenarios can show the exact ramp values and sweep boundaries, the timeout landing on schedule while the code is frozen, inputs being ignored during the delay sweep, and a clean restart after the enable is cycled.

// File: rtl/strike_sweep_pkg.sv
package strike_sweep_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ACTIVE  = 2'd1,
    SEQ_RUN     = 2'd2,
    SEQ_EXPIRED = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sweep_timebase.sv
// Phase and sweep counters; SWEEP_CLKS is expected to be a power of two.
module sweep_timebase #(
  parameter int SWEEP_CLKS = 1024,
  parameter int NUM_SWEEPS = 16,
  localparam int CYC_W = $clog2(SWEEP_CLKS),
  localparam int SW_W  = $clog2(NUM_SWEEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [CYC_W-1:0] phase,
  output logic [SW_W-1:0]  sweep,
  output logic             in_strike,
  output logic             at_end
);
  localparam logic [CYC_W-1:0] PH_LAST = CYC_W'(SWEEP_CLKS - 1);
  localparam logic [SW_W-1:0]  SW_LAST = SW_W'(NUM_SWEEPS - 1);

  logic ph_wrap;
  assign ph_wrap = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      phase <= '0;
      sweep <= '0;
    end else if (advance) begin
      phase <= ph_wrap ? '0 : phase + 1'b1;
      if (ph_wrap) sweep <= sweep + 1'b1;
    end
  end

  assign in_strike = (sweep != '0);
  assign at_end    = ph_wrap && (sweep == SW_LAST);
endmodule

// File: rtl/sweep_code_gen.sv
// Sawtooth ramp derived from the phase, with an over-voltage freeze latch.
module sweep_code_gen #(
  parameter int CYC_W  = 10,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              striking,
  input  logic              ovp,
  input  logic [CYC_W-1:0]  phase,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] ramp;
  logic [CODE_W-1:0] held_q;
  logic              frozen_q;

  generate
    if (CYC_W >= CODE_W) begin : g_shift_down
      assign ramp = phase[CYC_W-1 -: CODE_W];
    end else begin : g_shift_up
      assign ramp = {phase, {(CODE_W-CYC_W){1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      frozen_q <= 1'b0;
      held_q   <= '0;
    end else if (striking && ovp && !frozen_q) begin
      frozen_q <= 1'b1;
      held_q   <= ramp;
    end
  end

  always_comb begin
    if (!striking)     code = '0;
    else if (frozen_q) code = held_q;
    else               code = ramp;
  end
endmodule

// File: rtl/strike_seq_fsm.sv
module strike_seq_fsm
  import strike_sweep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic seq_en,
  input  logic ignited,
  input  logic in_strike,
  input  logic at_end,
  output logic clear,
  output logic advance,
  output logic striking,
  output logic timeout
);
  seq_state_t state_q, state_d;
  logic       expire;
  logic       lit;

  assign striking = (state_q == SEQ_ACTIVE) && in_strike;
  assign lit      = striking && ignited;
  assign expire   = striking && at_end && !ignited;

  always_comb begin
    state_d = state_q;
    if (!seq_en) state_d = SEQ_IDLE;
    else begin
      case (state_q)
        SEQ_IDLE:   state_d = SEQ_ACTIVE;
        SEQ_ACTIVE: begin
          if (lit)         state_d = SEQ_RUN;
          else if (expire) state_d = SEQ_EXPIRED;
        end
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      timeout <= 1'b0;
    end else begin
      state_q <= state_d;
      timeout <= seq_en && expire;
    end
  end

  assign clear   = !seq_en || (state_q == SEQ_IDLE);
  assign advance = (state_q == SEQ_ACTIVE) && !lit && !expire;
endmodule

// File: rtl/strike_sweep_gen.sv
module strike_sweep_gen #(
  parameter int SWEEP_CLKS = 1024,
  parameter int NUM_SWEEPS = 16,
  parameter int CODE_W     = 8,
  localparam int CYC_W = $clog2(SWEEP_CLKS),
  localparam int SW_W  = $clog2(NUM_SWEEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_en,
  input  logic              ovp,
  input  logic              ignited,
  output logic [CODE_W-1:0] dac_code,
  output logic              use_dac,
  output logic [SW_W-1:0]   sweep_idx,
  output logic              timeout
);
  logic             clear, advance, striking, in_strike, at_end;
  logic [CYC_W-1:0] phase;

  strike_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .ignited(ignited),
    .in_strike(in_strike), .at_end(at_end), .clear(clear),
    .advance(advance), .striking(striking), .timeout(timeout)
  );

  sweep_timebase #(.SWEEP_CLKS(SWEEP_CLKS), .NUM_SWEEPS(NUM_SWEEPS)) u_tb (
    .clk(clk), .rst_n(rst_n), .clear(clear), .advance(advance),
    .phase(phase), .sweep(sweep_idx), .in_strike(in_strike), .at_end(at_end)
  );

  sweep_code_gen #(.CYC_W(CYC_W), .CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .clear(clear), .striking(striking),
    .ovp(ovp), .phase(phase), .code(dac_code)
  );

  assign use_dac = striking;
endmodule

// File: rtl/strike_sweep_chk.sv
module strike_sweep_chk #(
  parameter int CODE_W = 8,
  parameter int SW_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_en,
  input logic              ovp,
  input logic              ignited,
  input logic [CODE_W-1:0] dac_code,
  input logic              use_dac,
  input logic [SW_W-1:0]   sweep_idx,
  input logic              timeout
);
  localparam logic [SW_W-1:0] SW_TOP = '1;

  // R9
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R9
  timeout_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!use_dac && sweep_idx == SW_TOP));

  // R7
  ignite_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_dac && ignited) |=> !use_dac);

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_dac && $past(use_dac) && $past(ovp)) |-> (dac_code == $past(dac_code)));

  // R2
  delay_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_dac |-> (sweep_idx != '0));

  // R1
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_en |=> (!use_dac && sweep_idx == '0 && !timeout));
endmodule

bind strike_sweep_gen strike_sweep_chk #(.CODE_W(CODE_W), .SW_W(SW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .ovp(ovp), .ignited(ignited),
  .dac_code(dac_code), .use_dac(use_dac), .sweep_idx(sweep_idx),
  .timeout(timeout)
);

// File: tb/tb_strike_sweep_gen.sv
`timescale 1ns/1ps
module tb_strike_sweep_gen;
  localparam int SPAN = 1024;
  localparam int LAST = 16 * SPAN - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_en = 1'b0, ovp = 1'b0, ignited = 1'b0;
  logic [7:0] dac_code;
  logic       use_dac;
  logic [3:0] sweep_idx;
  logic       timeout;

  int total = 0, bad = 0, cyc = 0;
  string ctx = "R1";

  // reference state: 0 idle, 1 active, 2 lit, 3 expired
  int m_st = 0, m_cnt = 0, m_hold = 0;
  bit m_frz = 0, m_to = 0;

  strike_sweep_gen dut (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .ovp(ovp), .ignited(ignited),
    .dac_code(dac_code), .use_dac(use_dac), .sweep_idx(sweep_idx),
    .timeout(timeout)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=190000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit m_strike();
    return (m_st == 1) && (m_cnt >= SPAN);
  endfunction

  function automatic int m_code();
    if (!m_strike()) return 0;
    if (m_frz) return m_hold;
    return (m_cnt % SPAN) / 4;
  endfunction

  task automatic model(input bit en, input bit ov, input bit ig);
    bit s;
    s = m_strike();
    m_to = 0;
    if (!en) begin
      m_st = 0; m_cnt = 0; m_frz = 0; m_hold = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_cnt = 0;
    end else if (m_st == 1) begin
      if (s && ov && !m_frz) begin m_frz = 1; m_hold = (m_cnt % SPAN) / 4; end
      if (s && ig) m_st = 2;
      else if (s && m_cnt == LAST) begin m_st = 3; m_to = 1; end
      else m_cnt++;
    end
  endtask

  task automatic compare();
    int es;
    es = m_cnt / SPAN;
    chk(use_dac == m_strike(), {ctx, " R7 select"}, use_dac, m_strike());
    chk(dac_code == m_code(), {ctx, " R4 code"}, dac_code, m_code());
    chk(sweep_idx == es, {ctx, " R3 sweep"}, sweep_idx, es);
    chk(timeout == m_to, {ctx, " R9 timeout"}, timeout, m_to);
  endtask

  task automatic step(input bit en, input bit ov, input bit ig);
    @(negedge clk);
    seq_en = en; ovp = ov; ignited = ig;
    @(posedge clk);
    model(en, ov, ig);
    #1;
    compare();
  endtask

  // ig_from..ig_to: window (in steps) where ignited is high; -1 disables
  task automatic run(input int len, input int ov_at, input int ig_from, input int ig_to);
    for (int i = 0; i < len; i++) begin
      bit ig;
      ig = (ig_from >= 0) && (i >= ig_from) && (i <= ig_to);
      step(1'b1, i == ov_at, ig);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(use_dac == 0 && dac_code == 0, "R1 reset select/code", {dac_code, 7'd0, use_dac}, 0);
    chk(sweep_idx == 0 && timeout == 0, "R1 reset sweep/timeout", {sweep_idx, 3'd0, timeout}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R2 R4 R9: full attempt with no ignition
    ctx = "R2";
    run(SPAN, -1, -1, -1);
    chk(use_dac == 0, "R2 delay end select", use_dac, 0);
    run(LAST + 20 - SPAN, -1, -1, -1);
    chk(timeout == 0 && sweep_idx == 15 && use_dac == 0, "R9 expired hold", sweep_idx, 15);
    idle(2);

    // R5: freeze in sweep 3, timeout still on schedule
    ctx = "R5";
    run(3 * SPAN + 400 + 700, 3 * SPAN + 400, -1, -1);
    chk(dac_code == 99 && sweep_idx == 4, "R5 held code across sweep", dac_code, 99);
    run(LAST + 20 - (3 * SPAN + 1100), -1, -1, -1);
    idle(2);

    // R6 R8: over-voltage and ignition during the delay are ignored
    ctx = "R6 R8";
    run(1100, 300, 200, 900);
    chk(use_dac == 1 && dac_code == (1099 - SPAN) / 4, "R8 strike after delay ignition", dac_code, (1099 - SPAN) / 4);
    run(200, -1, -1, -1);
    idle(2);

    // R7: ignition mid strike
    ctx = "R7";
    run(6000, -1, 5000, 6000);
    chk(use_dac == 0 && dac_code == 0 && sweep_idx == 4, "R7 run after ignition", sweep_idx, 4);
    idle(2);

    // R10: enable drop mid strike, then restart
    ctx = "R10";
    run(3000, 2000, -1, -1);
    idle(1);
    chk(use_dac == 0 && sweep_idx == 0, "R10 idle after drop", sweep_idx, 0);
    run(1500, -1, -1, -1);
    chk(use_dac == 1 && dac_code == (1499 - SPAN) / 4, "R10 restart unfrozen", dac_code, (1499 - SPAN) / 4);
    idle(2);

    // random attempts
    ctx = "RND";
    void'($urandom(32'h1A5E));
    for (int k = 0; k < 4; k++) begin
      int ov_at, ig_at;
      ov_at = ($urandom % 3 == 0) ? -1 : int'($urandom % (LAST + 1));
      ig_at = SPAN + int'($urandom % 19000);
      run(LAST + 30, ov_at, ig_at, LAST + 30);
      idle(2);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule